// File: doc/BRIEF.md
# Iterative Quotient-Remainder Divider

This block performs 32-bit integer division for a processor execution stage. A single `start` pulse hands it a dividend, a divisor and two decoded mode bits (`is_unsigned`, `is_half`). It then works for a fixed number of cycles, during which `busy` is high. After that it presents a quotient and a remainder, each meant for its own destination register. It also presents overflow, sign and zero flags. The carry flag of the surrounding machine is not touched: the block has no carry output.

Internally the block removes the operand signs and runs one restoring shift-subtract step per cycle over the magnitudes. The remaining cycles up to the mode's latency are idle padding. At the end it restores the signs of the quotient and the remainder and writes all results into output registers in one step. Those registers hold their values until the next division completes.

Top module: `iter_divider`

## Requirements
- R1: While `rst` is high and after it falls, before any `start`, `busy`, `done`, `quotient`, `remainder`, `flag_ov`, `flag_s` and `flag_z` are all zero.
- R2: A `start` accepted at a clock edge makes `done` high for exactly one cycle, after the 35th following edge when `is_unsigned`=0 and after the 34th when `is_unsigned`=1. `busy` is high from the accepting edge until `done` rises, and `busy` and `done` are never high together.
- R3: A `start` that arrives while `busy` is high is ignored. It changes neither the timing nor the results of the division in progress.
- R4: With `is_unsigned`=1 and `is_half`=0, `quotient` is floor(dividend/divisor) and `remainder` is dividend mod divisor, both as unsigned 32-bit values.
- R5: With `is_unsigned`=0, the operands are two's complement values. The quotient is truncated toward zero, and a nonzero remainder takes the sign of the dividend.
- R6: With `is_half`=1, only `divisor[15:0]` is used. It is sign-extended when `is_unsigned`=0 and zero-extended when `is_unsigned`=1. The dividend is always used at its full 32 bits.
- R7: When the effective divisor is zero, `flag_ov` is 1 at `done`.
- R8: With `is_unsigned`=0, a dividend of 0x80000000 and an effective divisor of 0xFFFFFFFF set `flag_ov`. The same operands with `is_unsigned`=1 give quotient 0, remainder 0x80000000 and `flag_ov`=0.
- R9: At `done`, `flag_s` equals bit 31 of `quotient` and `flag_z` is 1 exactly when `quotient` is zero.
- R10: `quotient`, `remainder` and the flags change only at the edge where `done` rises, and they hold afterwards, including after an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a division; accepted when not busy |
| is_unsigned | input | 1 | 1 = unsigned operands, 0 = signed |
| is_half | input | 1 | 1 = divisor taken from its low 16 bits |
| dividend | input | 32 | Dividend operand |
| divisor | input | 32 | Divisor operand |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse: results updated |
| quotient | output | 32 | Quotient, for the dividend's destination register |
| remainder | output | 32 | Remainder, for the second destination register |
| flag_ov | output | 1 | Overflow: zero divisor or signed range overflow |
| flag_s | output | 1 | Sign of the quotient |
| flag_z | output | 1 | Quotient is zero |

## Verification
The cycle counter and the step counter are separate. If the latency counter is loaded wrongly or decremented wrongly, `done` moves off its 34- or 35-cycle slot, and this shows at the very first division. A wrong partial remainder or a wrong quotient shift register shows at `done` of that same division as a wrong quotient or remainder. Sign-handling faults show only in mixed-sign or halfword cases. A stale or wrongly captured mode bit appears as a latency that is one cycle off, or as a result of the wrong sign. A missing start guard appears as a changed result when a second `start` is poked in mid-division.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef struct packed {
    logic uns;
    logic half;
  } div_mode_t;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep
  import div_pkg::*;
#(
  parameter int W  = 32,
  parameter int HW = 16
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  div_mode_t    mode,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b,
  output logic         neg_quo,
  output logic         neg_rem,
  output logic         ovf
);
  localparam int EXT_W = W - HW;
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] eff_b;
  logic         a_neg;
  logic         b_neg;

  // choose divisor view: full word or extended low half
  always_comb begin
    if (mode.half) begin
      if (mode.uns) eff_b = {{EXT_W{1'b0}}, op_b[HW-1:0]};
      else          eff_b = {{EXT_W{op_b[HW-1]}}, op_b[HW-1:0]};
    end else begin
      eff_b = op_b;
    end
  end

  always_comb begin
    a_neg   = !mode.uns && op_a[W-1];
    b_neg   = !mode.uns && eff_b[W-1];
    mag_a   = a_neg ? (~op_a + 1'b1) : op_a;
    mag_b   = b_neg ? (~eff_b + 1'b1) : eff_b;
    neg_quo = a_neg ^ b_neg;
    neg_rem = a_neg;
    ovf     = (eff_b == '0) ||
              (!mode.uns && (op_a == MOST_NEG) && (eff_b == {W{1'b1}}));
  end
endmodule

// File: rtl/div_sequencer.sv
module div_sequencer #(
  parameter int W     = 32,
  parameter int LAT_S = 35,
  parameter int LAT_U = 34
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic uns,
  output logic load,
  output logic step,
  output logic finish,
  output logic busy,
  output logic done
);
  localparam int LAT_MAX = (LAT_S > LAT_U) ? LAT_S : LAT_U;
  localparam int CNT_W   = $clog2(LAT_MAX + 1);
  localparam int SC_W    = $clog2(W + 1);

  logic [CNT_W-1:0] cnt;
  logic [SC_W-1:0]  sc;

  assign load   = start && !busy;
  assign step   = busy && (sc != SC_W'(W));
  assign finish = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      sc   <= '0;
    end else begin
      done <= finish;
      if (load) begin
        busy <= 1'b1;
        cnt  <= uns ? CNT_W'(LAT_U - 1) : CNT_W'(LAT_S - 1);
        sc   <= '0;
      end else if (busy) begin
        if (finish) busy <= 1'b0;
        else        cnt  <= cnt - 1'b1;
        if (step)   sc   <= sc + 1'b1;
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R2
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy && done)); // R2
  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != '0) |=> busy); // R3
  AST_STEPS_COMPLETE: assert property (@(posedge clk) disable iff (rst)
    finish |-> (sc == SC_W'(W))); // R2
endmodule

// File: rtl/div_core.sv
module div_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] mag_a,
  input  logic [W-1:0] mag_b,
  output logic [W-1:0] quo,
  output logic [W-1:0] part
);
  logic [W-1:0] dsr;
  logic [W:0]   trial;
  logic [W:0]   diff;

  always_comb begin
    trial = {part, quo[W-1]};
    diff  = trial - {1'b0, dsr};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quo  <= '0;
      part <= '0;
      dsr  <= '0;
    end else if (load) begin
      quo  <= mag_a;
      part <= '0;
      dsr  <= mag_b;
    end else if (step) begin
      if (!diff[W]) begin
        part <= diff[W-1:0];
        quo  <= {quo[W-2:0], 1'b1};
      end else begin
        part <= trial[W-1:0];
        quo  <= {quo[W-2:0], 1'b0};
      end
    end
  end

  AST_PART_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
    (dsr != '0) |-> (part < dsr)); // R4
endmodule

// File: rtl/iter_divider.sv
module iter_divider
  import div_pkg::*;
#(
  parameter int WIDTH        = 32,
  parameter int HALF_W       = 16,
  parameter int LAT_SIGNED   = 35,
  parameter int LAT_UNSIGNED = 34
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             is_unsigned,
  input  logic             is_half,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             flag_ov,
  output logic             flag_s,
  output logic             flag_z
);
  div_mode_t        mode;
  logic [WIDTH-1:0] mag_a, mag_b;
  logic             neg_quo, neg_rem, ovf;
  logic             load, step, finish;
  logic [WIDTH-1:0] core_q, core_r;
  logic             neg_quo_r, neg_rem_r, ovf_r;
  logic [WIDTH-1:0] fix_q, fix_r;

  assign mode.uns  = is_unsigned;
  assign mode.half = is_half;

  div_operand_prep #(.W(WIDTH), .HW(HALF_W)) prep_i (
    .op_a(dividend), .op_b(divisor), .mode(mode),
    .mag_a(mag_a), .mag_b(mag_b),
    .neg_quo(neg_quo), .neg_rem(neg_rem), .ovf(ovf)
  );

  div_sequencer #(.W(WIDTH), .LAT_S(LAT_SIGNED), .LAT_U(LAT_UNSIGNED)) seq_i (
    .clk(clk), .rst(rst), .start(start), .uns(is_unsigned),
    .load(load), .step(step), .finish(finish), .busy(busy), .done(done)
  );

  div_core #(.W(WIDTH)) core_i (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .mag_a(mag_a), .mag_b(mag_b), .quo(core_q), .part(core_r)
  );

  // sign info captured with the operands
  always_ff @(posedge clk) begin
    if (rst) begin
      neg_quo_r <= 1'b0;
      neg_rem_r <= 1'b0;
      ovf_r     <= 1'b0;
    end else if (load) begin
      neg_quo_r <= neg_quo;
      neg_rem_r <= neg_rem;
      ovf_r     <= ovf;
    end
  end

  always_comb begin
    fix_q = neg_quo_r ? (~core_q + 1'b1) : core_q;
    fix_r = neg_rem_r ? (~core_r + 1'b1) : core_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quotient  <= '0;
      remainder <= '0;
      flag_ov   <= 1'b0;
      flag_s    <= 1'b0;
      flag_z    <= 1'b0;
    end else if (finish) begin
      quotient  <= fix_q;
      remainder <= fix_r;
      flag_ov   <= ovf_r;
      flag_s    <= fix_q[WIDTH-1];
      flag_z    <= (fix_q == '0);
    end
  end

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(flag_ov))); // R10
endmodule

// File: tb/iter_divider_tb.sv
module iter_divider_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        is_unsigned = 1'b0;
  logic        is_half = 1'b0;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        busy, done, flag_ov, flag_s, flag_z;
  logic [31:0] quotient, remainder;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iter_divider dut_i (
    .clk(clk), .rst(rst), .start(start), .is_unsigned(is_unsigned),
    .is_half(is_half), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
    .flag_ov(flag_ov), .flag_s(flag_s), .flag_z(flag_z)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WDOG_LIMIT && !finished) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WDOG_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] a, input logic [31:0] b, input bit uns,
                       input bit half, output logic [31:0] q, output logic [31:0] r,
                       output bit ov);
    logic [31:0] d;
    d = half ? (uns ? {16'h0, b[15:0]} : {{16{b[15]}}, b[15:0]}) : b;
    q = '0; r = '0;
    ov = (d == 0) || (!uns && a == 32'h8000_0000 && d == 32'hFFFF_FFFF);
    if (!ov) begin
      if (uns) begin q = a / d; r = a % d; end
      else begin q = $signed(a) / $signed(d); r = $signed(a) % $signed(d); end
    end
  endtask

  // one division; optional second start mid-run (R3)
  task automatic run_div(input logic [31:0] a, input logic [31:0] b, input bit uns,
                         input bit half, input string tag, input bit poke);
    logic [31:0] eq, er, hold_q;
    bit ov, early;
    int lat;
    model(a, b, uns, half, eq, er, ov);
    lat = uns ? 34 : 35;
    @(negedge clk);
    dividend = a; divisor = b; is_unsigned = uns; is_half = half; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    dividend = ~a; divisor = 32'h3;
    early = 0;
    for (int k = 1; k <= lat; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k < lat && (done || !busy)) early = 1;
      if (poke && k == 5) begin
        is_unsigned = ~uns; is_half = ~half; start = 1'b1;
      end
      if (poke && k == 6) start = 1'b0;
    end
    check(!early, "R2", {tag, " busy/done before latency"}, 32'(early), 0);
    check(done && !busy, "R2", {tag, " done at latency"}, {30'b0, done, busy}, 32'h2);
    check(flag_ov == ov, ov ? (uns ? "R7" : "R8") : "R7", {tag, " overflow"}, 32'(flag_ov), 32'(ov));
    if (!ov) begin
      check(quotient == eq, poke ? "R3" : (half ? "R6" : (uns ? "R4" : "R5")), {tag, " quotient"}, quotient, eq);
      check(remainder == er, poke ? "R3" : (half ? "R6" : (uns ? "R4" : "R5")), {tag, " remainder"}, remainder, er);
      check(flag_s == eq[31] && flag_z == (eq == 0), "R9", {tag, " flags"},
            {30'b0, flag_s, flag_z}, {30'b0, eq[31], eq == 0});
    end
    hold_q = quotient;
    repeat (3) @(negedge clk);
    check(!done && quotient == hold_q, "R10", {tag, " result held"}, quotient, hold_q);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check(!busy && !done && quotient == 0 && remainder == 0 && !flag_ov && !flag_s && !flag_z,
          "R1", "outputs in reset", {busy, done, flag_ov, flag_s, flag_z, quotient[26:0]}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(!busy && !done && quotient == 0 && !flag_z, "R1", "outputs after reset",
          {busy, done, flag_z, quotient[28:0]}, 0);
  endtask

  initial begin
    test_reset();
    run_div(32'd100, 32'd7, 1, 0, "R4 u 100/7", 0);
    run_div(32'hFFFF_FFFF, 32'h10, 1, 0, "R4 u max/16", 0);
    run_div(32'd5, 32'd9, 1, 0, "R9 zero quotient", 0);
    run_div(-32'sd100, 32'd7, 0, 0, "R5 -100/7", 0);
    run_div(32'd100, -32'sd7, 0, 0, "R5 100/-7", 0);
    run_div(-32'sd100, -32'sd7, 0, 0, "R5 -100/-7", 0);
    run_div(32'd100, 32'hABCD_FFF9, 0, 1, "R6 signed half", 0);
    run_div(32'h0010_0000, 32'hABCD_FFF9, 1, 1, "R6 unsigned half", 0);
    run_div(32'd5, 32'd0, 1, 0, "R7 zero divisor", 0);
    run_div(32'd5, 32'h1234_0000, 0, 1, "R7 half zero divisor", 0);
    run_div(32'h8000_0000, 32'hFFFF_FFFF, 0, 0, "R8 signed range", 0);
    run_div(32'h8000_0000, 32'hFFFF_FFFF, 1, 0, "R8 unsigned same", 0);
    run_div(32'd1000, 32'd33, 1, 0, "R3 poke unsigned", 1);
    run_div(-32'sd1000, 32'd33, 0, 0, "R3 poke signed", 1);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule